// File: doc/BRIEF.md
# Three-Phase Memory Test Sequencer

This block drives a small word-wide memory through a plain single-port interface (address, write data, write strobe and read data) and checks it for faults. Each test run has three phases in a fixed order. The first phase checks the data lines. The second checks the address lines. The third checks that every cell can hold both a one and a zero in each bit. Because of this split, a failure points at the part that broke: the data wiring, the address wiring or the storage array.

A one-cycle `start` pulse launches a run. While the sequencer is busy, `start` is ignored. It raises `done` when the run ends, and `done` stays high until the next `start`. The run stops at the first miscompare. It then raises `fail` and keeps a report until the next launch: the phase code, the address, the value it expected and the value it read. The read port is assumed to be registered, so read data is compared one cycle after the read address is presented. The memory is DW bits wide with 2^AW words; the defaults are 8 and 4.

Top module: `sram_test_seq`

## Requirements
- R1: After reset, `done`, `fail` and `mem_we` are low and the sequencer waits for `start`.
- R2: The data-line phase comes first. For each bit b from 0 to DW-1 it writes the value 1<<b to address 0 (0x01, 0x02, … 0x80), reads address 0 on the next cycle, and compares the result one cycle later.
- R3: The address-line phase writes PAT (default 0xAA) to addresses 1, 2, 4 and 8 in ascending order. It then writes ~PAT (0x55) to address 0. Finally it reads the power-of-two addresses in ascending order and expects PAT at each one.
- R4: The cell phase writes offset+1 to every address from 0 upward, then reads all of them back. It then writes the bitwise inverse of offset+1 to every address and reads all of them back again.
- R5: A fault-free run makes 45 writes and ends with `fail` low. `done` is seen 3·DW+3·AW+1+6·2^AW = 133 clock edges after the edge that sampled `start`.
- R6: The run stops at the first miscompare. `done` rises on the edge after the compare cycle, and no write follows the miscompare.
- R7: On a miscompare, `fail` goes high with `done`. The report holds the phase code (1 for data lines, 2 for address lines, 3 for cells), the address, the expected data and the read data. The report stays stable until the next launch.
- R8: A `start` pulse while a run is in progress has no effect: the run length and the result are unchanged.
- R9: A `start` pulse while `done` is high begins a new run and clears `done` and `fail` on that edge.
- R10: `done` stays high until the next `start`, and `mem_we` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch pulse; honoured only when idle or done |
| done | output | 1 | Run finished; held until the next launch |
| fail | output | 1 | A miscompare ended the run |
| fail_phase | output | 2 | Phase code of the failure: 1 data lines, 2 address lines, 3 cells |
| fail_addr | output | AW | Address of the failing read |
| fail_exp | output | DW | Expected data at the failure |
| fail_act | output | DW | Data read at the failure |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Memory read data, valid one cycle after the read address |

## Verification
The bench models the memory and injects one fault per run, so that each phase is the first to catch something:
- A stuck write-data bit and a pair of shorted read-data bits must be caught in phase 1. A design that compares on the cycle the read is issued, or that shifts the walking bit wrongly, reports the wrong bit or misses the fault.
- An address line stuck at 0 or at 1 must be caught in phase 2 at the aliased address, with 0x55 read in place of 0xAA. This fails if the complement is written before the power-of-two addresses or if address 0 is left out.
- Cell faults that show up only on the first fill, or only on the inverted fill, check that both passes of phase 3 run.
- The exact cycle counts of passing and failing runs show whether the sequencer stops on the first error and whether it ignores a mid-run `start`.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DB_WR,
    S_DB_RD,
    S_DB_CMP,
    S_AB_WP,
    S_AB_W0,
    S_AB_RD,
    S_AB_CMP,
    S_DV_WR,
    S_DV_RD,
    S_DV_CMP,
    S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_DATA = 2'd1,
    PH_ADDR = 2'd2,
    PH_CELL = 2'd3
  } phase_e;

endpackage

// File: rtl/sbt_fsm.sv
module sbt_fsm
  import sbt_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mismatch,
  output seq_state_e    state,
  output logic [IW-1:0] idx,
  output logic          inv,
  output logic          launch
);

  localparam int          NW      = 1 << AW;
  localparam logic [IW-1:0] DB_LAST = IW'(DW - 1);
  localparam logic [IW-1:0] AB_LAST = IW'(AW - 1);
  localparam logic [IW-1:0] DV_LAST = IW'(NW - 1);

  seq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          inv_q, inv_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    inv_d   = inv_q;
    launch  = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE: begin
        if (start) begin
          launch  = 1'b1;
          state_d = S_DB_WR;
          idx_d   = '0;
          inv_d   = 1'b0;
        end
      end
      S_DB_WR: state_d = S_DB_RD;
      S_DB_RD: state_d = S_DB_CMP;
      S_DB_CMP: begin
        if (mismatch) begin
          state_d = S_DONE;
        end else if (idx_q == DB_LAST) begin
          state_d = S_AB_WP;
          idx_d   = '0;
        end else begin
          state_d = S_DB_WR;
          idx_d   = idx_q + 1'b1;
        end
      end
      S_AB_WP: begin
        if (idx_q == AB_LAST) begin
          state_d = S_AB_W0;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_AB_W0: state_d = S_AB_RD;
      S_AB_RD: state_d = S_AB_CMP;
      S_AB_CMP: begin
        if (mismatch) begin
          state_d = S_DONE;
        end else if (idx_q == AB_LAST) begin
          state_d = S_DV_WR;
          idx_d   = '0;
        end else begin
          state_d = S_AB_RD;
          idx_d   = idx_q + 1'b1;
        end
      end
      S_DV_WR: begin
        if (idx_q == DV_LAST) begin
          state_d = S_DV_RD;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_DV_RD: state_d = S_DV_CMP;
      S_DV_CMP: begin
        if (mismatch) begin
          state_d = S_DONE;
        end else if (idx_q == DV_LAST) begin
          idx_d = '0;
          if (inv_q) begin
            state_d = S_DONE;
          end else begin
            state_d = S_DV_WR;
            inv_d   = 1'b1;
          end
        end else begin
          state_d = S_DV_RD;
          idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      inv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      inv_q   <= inv_d;
    end
  end

  assign state = state_q;
  assign idx   = idx_q;
  assign inv   = inv_q;

endmodule

// File: rtl/sbt_patgen.sv
module sbt_patgen
  import sbt_pkg::*;
#(
  parameter int          DW  = 8,
  parameter int          AW  = 4,
  parameter int          IW  = 4,
  parameter logic [DW-1:0] PAT = 8'hAA
) (
  input  seq_state_e    state,
  input  logic [IW-1:0] idx,
  input  logic          inv,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          we,
  output logic [DW-1:0] exp_data,
  output logic          cmp_en,
  output phase_e        phase
);

  logic [DW-1:0] walk;
  logic [AW-1:0] pow2;
  logic [DW-1:0] incr;
  logic [DW-1:0] cell_val;

  assign walk     = DW'(1) << idx;
  assign pow2     = AW'(1) << idx;
  assign incr     = DW'(idx) + DW'(1);
  assign cell_val = inv ? ~incr : incr;

  always_comb begin
    addr  = '0;
    wdata = '0;
    phase = PH_NONE;
    unique case (state)
      S_DB_WR, S_DB_RD, S_DB_CMP: begin
        wdata = walk;
        phase = PH_DATA;
      end
      S_AB_WP, S_AB_RD, S_AB_CMP: begin
        addr  = pow2;
        wdata = PAT;
        phase = PH_ADDR;
      end
      S_AB_W0: begin
        wdata = ~PAT;
        phase = PH_ADDR;
      end
      S_DV_WR, S_DV_RD, S_DV_CMP: begin
        addr  = idx[AW-1:0];
        wdata = cell_val;
        phase = PH_CELL;
      end
      default: ;
    endcase
  end

  assign we       = (state == S_DB_WR) || (state == S_AB_WP) ||
                    (state == S_AB_W0) || (state == S_DV_WR);
  assign cmp_en   = (state == S_DB_CMP) || (state == S_AB_CMP) ||
                    (state == S_DV_CMP);
  assign exp_data = wdata;

endmodule

// File: rtl/sbt_result.sv
module sbt_result
  import sbt_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cmp_en,
  input  phase_e        phase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] exp_data,
  input  logic [DW-1:0] rdata,
  output logic          mismatch,
  output logic          fail,
  output logic [1:0]    fail_phase,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_act
);

  logic capture_en;

  assign mismatch   = cmp_en && (rdata != exp_data);
  assign capture_en = clear || mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail       <= 1'b0;
      fail_phase <= '0;
      fail_addr  <= '0;
      fail_exp   <= '0;
      fail_act   <= '0;
    end else if (capture_en) begin
      fail       <= !clear;
      fail_phase <= clear ? 2'd0 : phase;
      fail_addr  <= clear ? '0 : addr;
      fail_exp   <= clear ? '0 : exp_data;
      fail_act   <= clear ? '0 : rdata;
    end
  end

endmodule

// File: rtl/sram_test_seq.sv
module sram_test_seq
  import sbt_pkg::*;
#(
  parameter int          DW  = 8,
  parameter int          AW  = 4,
  parameter logic [DW-1:0] PAT = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          fail,
  output logic [1:0]    fail_phase,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_act,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);

  localparam int NW   = 1 << AW;
  localparam int CMAX = (DW > NW) ? DW : NW;
  localparam int IW   = (CMAX > 2) ? $clog2(CMAX) : 1;

  logic [1:0]    rst_sync;
  logic          rst_core_n;
  seq_state_e    state;
  logic [IW-1:0] idx;
  logic          inv;
  logic          launch;
  logic          mismatch;
  logic          cmp_en;
  logic [DW-1:0] exp_data;
  phase_e        phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  sbt_fsm #(.DW(DW), .AW(AW), .IW(IW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (start),
    .mismatch (mismatch),
    .state    (state),
    .idx      (idx),
    .inv      (inv),
    .launch   (launch)
  );

  sbt_patgen #(.DW(DW), .AW(AW), .IW(IW), .PAT(PAT)) u_pat (
    .state    (state),
    .idx      (idx),
    .inv      (inv),
    .addr     (mem_addr),
    .wdata    (mem_wdata),
    .we       (mem_we),
    .exp_data (exp_data),
    .cmp_en   (cmp_en),
    .phase    (phase)
  );

  sbt_result #(.DW(DW), .AW(AW)) u_res (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clear      (launch),
    .cmp_en     (cmp_en),
    .phase      (phase),
    .addr       (mem_addr),
    .exp_data   (exp_data),
    .rdata      (mem_rdata),
    .mismatch   (mismatch),
    .fail       (fail),
    .fail_phase (fail_phase),
    .fail_addr  (fail_addr),
    .fail_exp   (fail_exp),
    .fail_act   (fail_act)
  );

  assign done = (state == S_DONE);

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          fail,
  input logic [1:0]    fail_phase,
  input logic [AW-1:0] fail_addr,
  input logic [DW-1:0] fail_exp,
  input logic [DW-1:0] fail_act,
  input logic          mem_we
);

  assert_no_write_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);

  assert_done_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_report_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(fail) && $stable(fail_phase) && $stable(fail_addr) &&
                          $stable(fail_exp) && $stable(fail_act)));

  assert_fail_only_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  assert_phase_code_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (fail_phase != 2'd0));

  assert_report_differs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (fail_exp != fail_act));

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && !fail));

endmodule

bind sram_test_seq sbt_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .done       (done),
  .fail       (fail),
  .fail_phase (fail_phase),
  .fail_addr  (fail_addr),
  .fail_exp   (fail_exp),
  .fail_act   (fail_act),
  .mem_we     (mem_we)
);

// File: tb/sram_test_seq_tb.sv
`timescale 1ns/1ps
module sram_test_seq_tb;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       done;
  logic       fail;
  logic [1:0] fail_phase;
  logic [3:0] fail_addr;
  logic [7:0] fail_exp;
  logic [7:0] fail_act;
  logic [3:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_we;
  logic [7:0] mem_rdata;

  int checks = 0;
  int errs   = 0;

  // memory model with fault injection
  logic [7:0] arr [16];
  logic [7:0] wd_and;
  logic [3:0] addr_and, addr_or;
  logic [3:0] cell_addr;
  logic [7:0] cell_and, cell_or;
  int         sh;
  logic [3:0] m_ea;
  logic [7:0] m_wv, m_rv;

  // write log
  logic [3:0] wl_addr [512];
  logic [7:0] wl_data [512];
  int         wn = 0;

  sram_test_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .fail       (fail),
    .fail_phase (fail_phase),
    .fail_addr  (fail_addr),
    .fail_exp   (fail_exp),
    .fail_act   (fail_act),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_rdata  (mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    m_ea = (mem_addr & addr_and) | addr_or;
    if (mem_we) begin
      m_wv = mem_wdata & wd_and;
      if (m_ea == cell_addr) m_wv = (m_wv & cell_and) | cell_or;
      arr[m_ea] <= m_wv;
    end
    m_rv = arr[m_ea];
    if (sh >= 0) begin
      m_rv[sh]   = m_rv[sh] & m_rv[sh+1];
      m_rv[sh+1] = m_rv[sh];
    end
    mem_rdata <= m_rv;
  end

  always @(negedge clk) begin
    if (mem_we === 1'b1 && wn < 512) begin
      wl_addr[wn] <= mem_addr;
      wl_data[wn] <= mem_wdata;
      wn <= wn + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic no_faults();
    wd_and    = 8'hFF;
    addr_and  = 4'hF;
    addr_or   = 4'h0;
    cell_addr = 4'h0;
    cell_and  = 8'hFF;
    cell_or   = 8'h00;
    sh        = -1;
  endtask

  task automatic run_seq(input int poke_at, output int cyc, output int flags_at_launch);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    flags_at_launch = {30'd0, done, fail};
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == poke_at);
    end
    start = 1'b0;
    if (!done) chk("R5", "run watchdog done", 0, 1);
  endtask

  task automatic expect_fail(input string name, input int ecyc, input int ewrites,
                             input int ph, input int ad, input int ex, input int ac);
    int cyc, fl, base;
    base = wn;
    run_seq(0, cyc, fl);
    chk("R9", {name, " flags cleared at launch"}, fl, 0);
    chk("R6", {name, " cycles to done"}, cyc, ecyc);
    repeat (3) @(negedge clk);
    chk("R6", {name, " writes before stop"}, wn - base, ewrites);
    chk("R7", {name, " fail"}, fail, 1);
    chk("R7", {name, " phase"}, fail_phase, ph);
    chk("R7", {name, " addr"}, fail_addr, ad);
    chk("R7", {name, " expected"}, fail_exp, ex);
    chk("R7", {name, " actual"}, fail_act, ac);
    chk("R10", {name, " done held"}, done, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    no_faults();
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", done, 0);
    chk("R1", "fail in reset", fail, 0);
    chk("R1", "we in reset", mem_we, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "done after reset", done, 0);
    chk("R1", "we after reset", mem_we, 0);
  endtask

  task automatic t_clean();
    int cyc, fl, base;
    no_faults();
    base = wn;
    run_seq(0, cyc, fl);
    chk("R5", "clean cycles", cyc, 133);
    chk("R5", "clean fail", fail, 0);
    repeat (4) @(negedge clk);
    chk("R10", "clean done held", done, 1);
    chk("R10", "no write in done", mem_we, 0);
    chk("R5", "clean write count", wn - base, 45);
    for (int b = 0; b < 8; b++)
      chk("R2", $sformatf("walk write %0d", b),
          {wl_addr[base+b], wl_data[base+b]}, {4'h0, 8'(1 << b)});
    for (int k = 0; k < 4; k++)
      chk("R3", $sformatf("pow2 write %0d", k),
          {wl_addr[base+8+k], wl_data[base+8+k]}, {4'(1 << k), 8'hAA});
    chk("R3", "complement write", {wl_addr[base+12], wl_data[base+12]}, {4'h0, 8'h55});
    for (int i = 0; i < 16; i++) begin
      chk("R4", $sformatf("fill write %0d", i),
          {wl_addr[base+13+i], wl_data[base+13+i]}, {4'(i), 8'(i + 1)});
      chk("R4", $sformatf("inverse write %0d", i),
          {wl_addr[base+29+i], wl_data[base+29+i]}, {4'(i), ~8'(i + 1)});
    end
  endtask

  task automatic t_busy_start();
    int cyc, fl;
    no_faults();
    run_seq(50, cyc, fl);
    chk("R8", "mid-run start cycles", cyc, 133);
    chk("R8", "mid-run start fail", fail, 0);
  endtask

  initial begin
    t_reset();
    t_clean();
    no_faults(); wd_and = 8'hF7;
    expect_fail("R2 stuck write bit3", 12, 4, 1, 0, 8'h08, 8'h00);
    no_faults(); sh = 1;
    expect_fail("R2 shorted read bits1-2", 6, 2, 1, 0, 8'h02, 8'h00);
    no_faults(); addr_and = 4'hB;
    expect_fail("R3 addr bit2 stuck0", 35, 13, 2, 4, 8'hAA, 8'h55);
    no_faults(); addr_or = 4'h1;
    expect_fail("R3 addr bit0 stuck1", 31, 13, 2, 1, 8'hAA, 8'h55);
    no_faults(); cell_addr = 4'd5; cell_or = 8'h01;
    expect_fail("R4 cell5 bit0 stuck1", 65, 29, 3, 5, 8'h06, 8'h07);
    no_faults(); cell_addr = 4'd13; cell_and = 8'h7F;
    expect_fail("R4 cell13 bit7 stuck0", 129, 45, 3, 13, 8'hF1, 8'h71);
    t_busy_start();
    t_clean();
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errs++;
    $display("FAIL R5 watchdog expired: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

endmodule